// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This block keeps the four 9-bit offset registers that set the almost-empty and almost-full thresholds of a FIFO. A low `load_n` turns the shared write and read strobes away from FIFO traffic and toward the offset registers. A write strobe loads `wr_data` into one register. A read strobe copies one register onto `rd_data`.

A single two-bit selector picks the register for each access and steps in a fixed cycle: empty-low, empty-high, full-low, full-high, then back to empty-low. Leaving load mode does not clear the selector, so a later load session resumes where the last one stopped. The two 18-bit thresholds, `n_offset` and `m_offset`, go straight to the flag logic outside this block. Both strobes are sampled on one clock, `clk`.

Top module: `fifo_ofs_loader`

## Requirements
- R1: While reset is low and after it is released, `n_offset` and `m_offset` both read 18'h00007 (low halves 9'h007, high halves 9'h000), `rd_data` reads 0, and the selector points at the empty-low register.
- R2: A rising `clk` edge with `load_n`=0 and `wr_en_n`=0 stores `wr_data` into the selected register, then advances the selector. Successive writes fill `n_offset[8:0]`, then `n_offset[17:9]`, then `m_offset[8:0]`, then `m_offset[17:9]`.
- R3: After an access to the full-high register, the next access targets the empty-low register again.
- R4: Edges with `load_n`=1 leave the selector unchanged, so the first access after load mode is re-entered uses the register after the last one accessed.
- R5: A rising edge with `load_n`=0, `rd_en_n`=0 and `wr_en_n`=1 copies the selected register onto `rd_data`, which is valid after that edge. The selector then advances in the same order as for writes.
- R6: With `load_n`=0 and both enables high, no register, selector position or `rd_data` changes, and neither FIFO request is raised.
- R7: With `load_n`=1, `fifo_wr_req` equals the inverse of `wr_en_n` and `fifo_rd_req` equals the inverse of `rd_en_n`, combinationally, and the offset registers do not change. With `load_n`=0, both requests are 0.
- R8: When an offset write and an offset read are requested on the same edge, the write is performed, `rd_data` keeps its value, and the selector advances by exactly one.
- R9: `rd_data` holds its value on every edge that performs no offset read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both strobes |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_n | input | 1 | Low selects offset register access |
| wr_en_n | input | 1 | Write strobe, active low |
| rd_en_n | input | 1 | Read strobe, active low |
| wr_data | input | 9 | Data written into an offset register |
| rd_data | output | 9 | Read-back of the last offset register read |
| fifo_wr_req | output | 1 | Write strobe passed through to the FIFO |
| fifo_rd_req | output | 1 | Read strobe passed through to the FIFO |
| n_offset | output | 18 | Almost-empty threshold, {empty-high, empty-low} |
| m_offset | output | 18 | Almost-full threshold, {full-high, full-low} |

## Verification
The bench targets the following corner cases:
- **Selector wrap.** The bench runs past the fourth register. A selector that saturates, or that does not wrap, would overwrite the full-high register again instead of returning to empty-low.
- **Leaving and re-entering load mode.** The bench exits load mode in the middle of the sequence, sends FIFO traffic, then re-enters. A selector that resets on leaving load mode would write into empty-low a second time.
- **Simultaneous write and read.** On this edge a design that stepped the selector twice would skip a register. A design that let the read through would change `rd_data`.
- **No-operation edges and normal traffic.** A decode that ignored `load_n`, or that treated a high enable as active, would corrupt the thresholds or leak a FIFO request.

// File: rtl/fifo_ofs_loader.sv
module fifo_ofs_loader #(
  parameter int W       = 9,
  parameter int NREG    = 4,
  parameter logic [W-1:0] LO_DEFAULT = 9'h007,
  parameter logic [W-1:0] HI_DEFAULT = 9'h000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_n,
  input  logic           wr_en_n,
  input  logic           rd_en_n,
  input  logic [W-1:0]   wr_data,
  output logic [W-1:0]   rd_data,
  output logic           fifo_wr_req,
  output logic           fifo_rd_req,
  output logic [2*W-1:0] n_offset,
  output logic [2*W-1:0] m_offset
);

  localparam int SW = $clog2(NREG);

  logic [W-1:0]  ofs [NREG];
  logic [SW-1:0] sel;
  logic          cfg_wr, cfg_rd;

  assign cfg_wr      = !load_n && !wr_en_n;
  assign cfg_rd      = !load_n && !rd_en_n && wr_en_n;
  assign fifo_wr_req = load_n && !wr_en_n;
  assign fifo_rd_req = load_n && !rd_en_n;
  assign n_offset    = {ofs[1], ofs[0]};
  assign m_offset    = {ofs[3], ofs[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel     <= '0;
      rd_data <= '0;
    end else if (cfg_wr || cfg_rd) begin
      sel <= sel + 1'b1;
      if (cfg_rd) rd_data <= ofs[sel];
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ofs[i] <= (i % 2 == 0) ? LO_DEFAULT : HI_DEFAULT;
      else if (cfg_wr && sel == SW'(i))
        ofs[i] <= wr_data;
    end
  end

  // R4
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> $stable(sel));

  // R7
  ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> ($stable(n_offset) && $stable(m_offset)));

  // R8
  rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !wr_en_n) |=> $stable(rd_data));

  // R6
  nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && wr_en_n && rd_en_n) |=> ($stable(sel) && $stable(rd_data) && $stable(n_offset) && $stable(m_offset)));

  // R7
  always_comb if (rst_n && !load_n) no_leak_chk: assert (!fifo_wr_req && !fifo_rd_req);

endmodule

// File: tb/tb_fifo_ofs_loader.sv
`timescale 1ns/1ps
module tb_fifo_ofs_loader;
  logic clk = 0, rst_n = 0, load_n = 1, wr_en_n = 1, rd_en_n = 1;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic fifo_wr_req, fifo_rd_req;
  logic [17:0] n_offset, m_offset;

  fifo_ofs_loader dut (.clk(clk), .rst_n(rst_n), .load_n(load_n), .wr_en_n(wr_en_n),
    .rd_en_n(rd_en_n), .wr_data(wr_data), .rd_data(rd_data), .fifo_wr_req(fifo_wr_req),
    .fifo_rd_req(fifo_rd_req), .n_offset(n_offset), .m_offset(m_offset));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int mreg [4] = '{7, 0, 7, 0};
  int msel = 0;
  int mrd = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_all(string req);
    chk(req, int'(n_offset), mreg[1] * 512 + mreg[0]);
    chk(req, int'(m_offset), mreg[3] * 512 + mreg[2]);
    chk(req, int'(rd_data), mrd);
  endtask

  task automatic step(string req, bit ld, bit we, bit re, int d);
    bit cw, cr;
    load_n = ld; wr_en_n = we; rd_en_n = re; wr_data = 9'(d);
    #1;
    chk(req, int'(fifo_wr_req), (ld && !we) ? 1 : 0);
    chk(req, int'(fifo_rd_req), (ld && !re) ? 1 : 0);
    @(posedge clk);
    cw = !ld && !we;
    cr = !ld && !re && !cw;
    if (cw) begin mreg[msel] = d; msel = (msel + 1) % 4; end
    else if (cr) begin mrd = mreg[msel]; msel = (msel + 1) % 4; end
    @(negedge clk);
    cmp_all(req);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp_all("R1");
    rst_n = 1;
    @(negedge clk);
    cmp_all("R1");
    // R2: first two registers
    step("R2", 0, 0, 1, 9'h1A5);
    step("R2", 0, 0, 1, 9'h0C3);
    // R7: normal traffic, offsets untouched
    step("R7", 1, 0, 1, 9'h1FF);
    step("R7", 1, 1, 0, 9'h111);
    step("R7", 1, 0, 0, 9'h122);
    // R4: resume with full-low
    step("R4", 0, 0, 1, 9'h055);
    step("R2", 0, 0, 1, 9'h1E1);
    // R3: wrap to empty-low
    step("R3", 0, 0, 1, 9'h033);
    // R5: read back, continuing sequence
    for (int i = 0; i < 5; i++) step("R5", 0, 1, 0, 0);
    // R6: no operation
    step("R6", 0, 1, 1, 9'h1FF);
    step("R6", 0, 1, 1, 9'h0AA);
    // R8: simultaneous write and read
    step("R8", 0, 0, 0, 9'h0F0);
    step("R8", 0, 0, 0, 9'h10F);
    step("R8", 0, 1, 0, 0);
    // R9: rd_data holds without read
    step("R9", 1, 1, 1, 0);
    step("R9", 0, 0, 1, 9'h077);
    // R4 again: leave and re-enter, then read the rest
    step("R4", 1, 1, 1, 0);
    for (int i = 0; i < 6; i++) step("R4", 0, 1, 0, 0);
    // R1: reset mid-run restores defaults and selector
    rst_n = 0; load_n = 1; wr_en_n = 1; rd_en_n = 1;
    mreg = '{7, 0, 7, 0}; msel = 0; mrd = 0;
    @(negedge clk);
    cmp_all("R1");
    rst_n = 1;
    step("R1", 0, 0, 1, 9'h099);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule